// File: doc/BRIEF.md
# Platform-level interrupt controller

This block gathers level-sensitive interrupt requests from up to 1023 numbered sources and forwards them to a set of target contexts (typically one per privilege level of each processor core). Every source has a programmable priority; every context has its own per-source enable mask, a priority threshold, a single interrupt line and a claim/complete register. For each context the block continuously selects the best source whose request is latched, enabled for that context and of a priority strictly above the context's threshold. The interrupt line of a context is high whenever such a source exists.

Software services an interrupt by reading the context's claim/complete register. The read returns the winning source number and moves that source into a claimed state, so no context sees it again until software writes the same number back to any claim/complete register. Source number 0 is reserved and means "nothing to claim".

Each source is governed by a three-state gateway machine. `GATE_IDLE` moves to `GATE_PEND` (transition *latch*) when the request line is high. `GATE_PEND` moves to `GATE_BUSY` (transition *claim*) when a claim read picks it. `GATE_BUSY` moves to `GATE_PEND` (transition *complete-rearm*) when completed with its request still high, or to `GATE_IDLE` (transition *complete-release*) when completed with its request low. Every other case holds the state. The register port accepts one access per cycle: a write takes effect at the clock edge of the request, and read data comes back on the next cycle.

Top module: `irq_router`

## Requirements
- R1: The priority of source n (1..NUM_SRC) sits at byte address 4*n, holds PRIO_W bits taken from the low bits of the write data, and reads back zero-extended. The word at address 0 (source 0) reads 0 and ignores writes.
- R2: The enable word w of context c sits at 0x2000 + 0x80*c + 4*w. Bit b of that word enables source 32*w + b. Bits naming source 0 or a source above NUM_SRC read 0.
- R3: The threshold of context c sits at 0x200000 + 0x1000*c, holds PRIO_W bits and reads back zero-extended.
- R4: ctx_irq[c] is high exactly when some source is latched, enabled for c and has a priority strictly greater than c's threshold. It follows a register write or a source state change in the cycle after that clock edge.
- R5: A source with priority 0 never drives an interrupt or wins a claim, even while latched. Writing a nonzero priority lets the latched request through.
- R6: A read of context c's claim/complete register (0x200000 + 0x1000*c + 4) returns the number of the qualifying source with the highest priority, the lowest number winning a tie. It returns 0 when no source qualifies.
- R7: A claimed source stops counting for every context and is not reported again while claimed, even with its request line still high.
- R8: Writing a claimed source's number to any context's claim/complete register completes it. The source is latched again at once if its request is still high, and becomes idle otherwise.
- R9: A completion write naming a source that is not claimed, or naming 0, changes nothing.
- R10: Writes to unmapped or misaligned addresses (low two address bits nonzero) change nothing, and reads from them return 0. Contexts at or above NUM_CTX and priority words above NUM_SRC count as unmapped.
- R11: reg_rvalid rises for exactly one cycle, one cycle after each read request, and never after a write.
- R12: After reset all priorities, enables and thresholds are 0, no source is latched or claimed, and every ctx_irq is low.
- R13: A source whose request line is high at a clock edge stays latched after the line drops, until it is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_lvl | input | NUM_SRC | Level request of sources 1..NUM_SRC (bit n is source n) |
| reg_req | input | 1 | Register access request, one access per cycle |
| reg_write | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | 26 | Byte address of the 32-bit register |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| reg_rdata | output | 32 | Read data |
| ctx_irq | output | NUM_CTX | Interrupt line of each context |

## Verification
The bench builds the block with 40 sources, two contexts and 3-bit priorities. Forty sources put valid sources in a second enable word and leave a partly filled upper word, so the enable bit mapping and the unmapped bits above the last source are both reachable. Two contexts allow checks that a claim through one context hides the source from the other and that a completion through either context releases it. Three priority bits make the truncation of wide writes and the strict threshold comparison observable with small values.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int ADDR_W     = 26;
    localparam int CSEL_W     = 14;
    localparam int PRIO_LIMIT = 32'h0000_1000;
    localparam int EN_BASE    = 32'h0000_2000;
    localparam int EN_STRIDE  = 32'h0000_0080;
    localparam int CTX_BASE   = 32'h0020_0000;
    localparam int CTX_STRIDE = 32'h0000_1000;
    localparam int MAX_SRC    = 1023;

    typedef enum logic [1:0] {
        GATE_IDLE = 2'd0,
        GATE_PEND = 2'd1,
        GATE_BUSY = 2'd2
    } gate_state_t;

    typedef enum logic [2:0] {
        ACC_NONE   = 3'd0,
        ACC_PRIO   = 3'd1,
        ACC_ENABLE = 3'd2,
        ACC_THRESH = 3'd3,
        ACC_CLAIM  = 3'd4
    } acc_kind_t;

endpackage

// File: rtl/irq_src_gate.sv
module irq_src_gate
    import irq_router_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pending_o
);

    gate_state_t state_q;
    gate_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GATE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_IDLE: begin
                if (lvl_i) begin
                    state_d = GATE_PEND;            // latch
                end
            end
            GATE_PEND: begin
                if (claim_i) begin
                    state_d = GATE_BUSY;            // claim
                end
            end
            GATE_BUSY: begin
                if (complete_i) begin
                    state_d = lvl_i ? GATE_PEND     // complete-rearm
                                    : GATE_IDLE;    // complete-release
                end
            end
            default: state_d = GATE_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pending_o = (state_q == GATE_PEND);
    end

    assert_claim_only_pending_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        claim_i |-> (state_q == GATE_PEND));

    assert_busy_holds_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == GATE_BUSY && !complete_i) |=> (state_q == GATE_BUSY));

    assert_pend_holds_R13: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == GATE_PEND && !claim_i) |=> (state_q == GATE_PEND));

endmodule

// File: rtl/irq_ctx_arb.sv
module irq_ctx_arb #(
    parameter int NUM_SRC = 31,
    parameter int PRIO_W  = 3,
    localparam int ID_W   = $clog2(NUM_SRC + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC:0]               pend_i,
    input  logic [NUM_SRC:0]               en_i,
    input  logic [NUM_SRC:0][PRIO_W-1:0]   prio_i,
    input  logic [PRIO_W-1:0]              thr_i,
    output logic [ID_W-1:0]                id_o,
    output logic                           irq_o
);

    logic [PRIO_W-1:0] best_p;

    // Ascending scan with a strict compare: the first source reaching a
    // priority level keeps it, so equal priorities go to the lowest number.
    // Starting from the threshold removes everything at or below it.
    always_comb begin
        id_o   = '0;
        best_p = thr_i;
        for (int n = 1; n <= NUM_SRC; n++) begin
            if (pend_i[n] && en_i[n] && (prio_i[n] != '0) && (prio_i[n] > best_p)) begin
                id_o   = ID_W'(n);
                best_p = prio_i[n];
            end
        end
    end

    always_comb begin
        irq_o = (id_o != '0);
    end

    assert_grant_qualified_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_i[id_o] && en_i[id_o] && (prio_i[id_o] > thr_i)));

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 31,
    parameter int NUM_CTX = 2,
    parameter int PRIO_W  = 3,
    localparam int ENW    = (NUM_SRC + 32) / 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_i,
    input  logic                                we_i,
    input  logic [ADDR_W-1:0]                   addr_i,
    input  logic [31:0]                         wdata_i,
    output acc_kind_t                           kind_o,
    output logic [CSEL_W-1:0]                   ctx_o,
    output logic [31:0]                         rdata_o,
    output logic [NUM_SRC:0][PRIO_W-1:0]        prio_o,
    output logic [NUM_CTX-1:0][NUM_SRC:0]       en_o,
    output logic [NUM_CTX-1:0][PRIO_W-1:0]      thr_o
);

    logic [NUM_SRC:0][PRIO_W-1:0]   prio_q;
    logic [NUM_CTX-1:0][NUM_SRC:0]  en_q;
    logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q;

    logic [ADDR_W-1:0] off_en;
    logic [ADDR_W-1:0] off_ctx;
    logic [9:0]        sel_src;
    logic [4:0]        sel_word;
    acc_kind_t         kind;
    logic [CSEL_W-1:0] sel_ctx;
    logic              wr_go;

    // address decode
    always_comb begin
        off_en   = addr_i - ADDR_W'(EN_BASE);
        off_ctx  = addr_i - ADDR_W'(CTX_BASE);
        sel_src  = addr_i[11:2];
        sel_word = off_en[6:2];
        kind     = ACC_NONE;
        sel_ctx  = '0;
        if (addr_i[1:0] == 2'b00) begin
            if (addr_i < ADDR_W'(PRIO_LIMIT)) begin
                if ((sel_src != '0) && (int'(sel_src) <= NUM_SRC)) begin
                    kind = ACC_PRIO;
                end
            end else if ((addr_i >= ADDR_W'(EN_BASE)) &&
                         (addr_i < ADDR_W'(EN_BASE + NUM_CTX * EN_STRIDE))) begin
                sel_ctx = off_en[20:7];
                if (int'(sel_word) < ENW) begin
                    kind = ACC_ENABLE;
                end
            end else if ((addr_i >= ADDR_W'(CTX_BASE)) &&
                         (addr_i < ADDR_W'(CTX_BASE + NUM_CTX * CTX_STRIDE))) begin
                sel_ctx = off_ctx[25:12];
                if (off_ctx[11:0] == 12'h000) begin
                    kind = ACC_THRESH;
                end else if (off_ctx[11:0] == 12'h004) begin
                    kind = ACC_CLAIM;
                end
            end
        end
    end

    always_comb begin
        wr_go = req_i && we_i;
    end

    // priority storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else if (wr_go && kind == ACC_PRIO) begin
            for (int n = 1; n <= NUM_SRC; n++) begin
                if (sel_src == 10'(n)) begin
                    prio_q[n] <= wdata_i[PRIO_W-1:0];
                end
            end
        end
    end

    // enable storage, one generated bank per context
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_en_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[c] <= '0;
            end else if (wr_go && kind == ACC_ENABLE && sel_ctx == CSEL_W'(c)) begin
                for (int n = 1; n <= NUM_SRC; n++) begin
                    if (sel_word == 5'(n / 32)) begin
                        en_q[c][n] <= wdata_i[n % 32];
                    end
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                thr_q[c] <= '0;
            end else if (wr_go && kind == ACC_THRESH && sel_ctx == CSEL_W'(c)) begin
                thr_q[c] <= wdata_i[PRIO_W-1:0];
            end
        end
    end

    // read mux for the plain configuration registers
    always_comb begin
        rdata_o = '0;
        unique case (kind)
            ACC_PRIO: begin
                for (int n = 1; n <= NUM_SRC; n++) begin
                    if (sel_src == 10'(n)) begin
                        rdata_o = 32'(prio_q[n]);
                    end
                end
            end
            ACC_ENABLE: begin
                for (int c = 0; c < NUM_CTX; c++) begin
                    for (int n = 1; n <= NUM_SRC; n++) begin
                        if (sel_ctx == CSEL_W'(c) && sel_word == 5'(n / 32)) begin
                            rdata_o[n % 32] = en_q[c][n];
                        end
                    end
                end
            end
            ACC_THRESH: begin
                for (int c = 0; c < NUM_CTX; c++) begin
                    if (sel_ctx == CSEL_W'(c)) begin
                        rdata_o = 32'(thr_q[c]);
                    end
                end
            end
            default: rdata_o = '0;
        endcase
    end

    always_comb begin
        kind_o = kind;
        ctx_o  = sel_ctx;
        prio_o = prio_q;
        en_o   = en_q;
        thr_o  = thr_q;
    end

    assert_src0_prio_zero_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        prio_q[0] == '0);

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 31,
    parameter int NUM_CTX = 2,
    parameter int PRIO_W  = 3,
    localparam int ID_W   = $clog2(NUM_SRC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC:1]     src_lvl,
    input  logic                 reg_req,
    input  logic                 reg_write,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic                 reg_rvalid,
    output logic [31:0]          reg_rdata,
    output logic [NUM_CTX-1:0]   ctx_irq
);

    acc_kind_t                       kind;
    logic [CSEL_W-1:0]               sel_ctx;
    logic [31:0]                     cfg_rdata;
    logic [NUM_SRC:0][PRIO_W-1:0]    prio;
    logic [NUM_CTX-1:0][NUM_SRC:0]   en;
    logic [NUM_CTX-1:0][PRIO_W-1:0]  thr;
    logic [NUM_SRC:0]                pend;
    logic [ID_W-1:0]                 arb_id [NUM_CTX];
    logic [ID_W-1:0]                 sel_id;
    logic                            claim_go;
    logic                            cmpl_go;
    logic                            rvalid_q;
    logic [31:0]                     rdata_q;

    irq_cfg_regs #(
        .NUM_SRC (NUM_SRC),
        .NUM_CTX (NUM_CTX),
        .PRIO_W  (PRIO_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (reg_req),
        .we_i    (reg_write),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .kind_o  (kind),
        .ctx_o   (sel_ctx),
        .rdata_o (cfg_rdata),
        .prio_o  (prio),
        .en_o    (en),
        .thr_o   (thr)
    );

    // winner of the addressed context
    always_comb begin
        sel_id = '0;
        for (int c = 0; c < NUM_CTX; c++) begin
            if (sel_ctx == CSEL_W'(c)) begin
                sel_id = arb_id[c];
            end
        end
    end

    always_comb begin
        claim_go = reg_req && !reg_write && (kind == ACC_CLAIM);
        cmpl_go  = reg_req &&  reg_write && (kind == ACC_CLAIM) &&
                   (reg_wdata[31:ID_W] == '0);
    end

    assign pend[0] = 1'b0;

    for (genvar n = 1; n <= NUM_SRC; n++) begin : g_gate
        irq_src_gate u_gate (
            .clk        (clk),
            .rst_n      (rst_n),
            .lvl_i      (src_lvl[n]),
            .claim_i    (claim_go && (sel_id == ID_W'(n))),
            .complete_i (cmpl_go && (reg_wdata[ID_W-1:0] == ID_W'(n))),
            .pending_o  (pend[n])
        );
    end

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_arb
        irq_ctx_arb #(
            .NUM_SRC (NUM_SRC),
            .PRIO_W  (PRIO_W)
        ) u_arb (
            .clk    (clk),
            .rst_n  (rst_n),
            .pend_i (pend),
            .en_i   (en[c]),
            .prio_i (prio),
            .thr_i  (thr[c]),
            .id_o   (arb_id[c]),
            .irq_o  (ctx_irq[c])
        );
    end

    // read response register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= reg_req && !reg_write;
            if (reg_req && !reg_write) begin
                rdata_q <= (kind == ACC_CLAIM) ? 32'(sel_id) : cfg_rdata;
            end else begin
                rdata_q <= '0;
            end
        end
    end

    assign reg_rvalid = rvalid_q;
    assign reg_rdata  = rdata_q;

    assert_rvalid_after_read_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        reg_rvalid |-> $past(reg_req && !reg_write));

    assert_no_data_without_read_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        !reg_rvalid |-> (reg_rdata == '0));

endmodule

// File: tb/test_irq_router.sv
module test_irq_router;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 40;
    localparam int NCTX = 2;
    localparam int PW   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC:1]   src_lvl = '0;
    logic            reg_req = 1'b0;
    logic            reg_write = 1'b0;
    logic [25:0]     reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic            reg_rvalid;
    logic [31:0]     reg_rdata;
    logic [NCTX-1:0] ctx_irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_router #(.NUM_SRC(NSRC), .NUM_CTX(NCTX), .PRIO_W(PW)) i_irq_router (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_lvl    (src_lvl),
        .reg_req    (reg_req),
        .reg_write  (reg_write),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rvalid (reg_rvalid),
        .reg_rdata  (reg_rdata),
        .ctx_irq    (ctx_irq)
    );

    function automatic logic [25:0] a_prio(input int n);
        return 26'(4 * n);
    endfunction
    function automatic logic [25:0] a_en(input int c, input int w);
        return 26'(32'h2000 + 32'h80 * c + 4 * w);
    endfunction
    function automatic logic [25:0] a_thr(input int c);
        return 26'(32'h20_0000 + 32'h1000 * c);
    endfunction
    function automatic logic [25:0] a_clm(input int c);
        return 26'(32'h20_0000 + 32'h1000 * c + 4);
    endfunction

    // monitor: compares read responses with the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fails++;
                $display("FAIL R11: unexpected rvalid, rdata=%h expected no response", reg_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    n_fails++;
                    $display("FAIL %s: rdata=%h expected %h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [25:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_req = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_req = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [25:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        reg_req = 1'b1; reg_write = 1'b0; reg_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        reg_req = 1'b0;
    endtask

    task automatic chk_irq(input logic [NCTX-1:0] e, input string t);
        n_checks++;
        if (ctx_irq !== e) begin
            n_fails++;
            $display("FAIL %s: ctx_irq=%b expected %b", t, ctx_irq, e);
        end
    endtask

    task automatic pulse(input logic [NSRC:1] m);
        @(negedge clk);
        src_lvl = src_lvl | m;
        @(negedge clk);
        src_lvl = src_lvl & ~m;
    endtask

    function automatic logic [NSRC:1] bit_of(input int n);
        logic [NSRC:1] v;
        v = '0;
        v[n] = 1'b1;
        return v;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk_irq(2'b00, "R12 irq after reset");
        rd(a_prio(3), 32'h0, "R12 prio reset");
        rd(a_thr(1), 32'h0, "R12 threshold reset");
        rd(a_en(0, 0), 32'h0, "R12 enable reset");
        rd(a_clm(0), 32'h0, "R12 claim empty");

        // R1: priority map and truncation, source 0 reserved
        wr(a_prio(5), 32'hFF);
        rd(a_prio(5), 32'h7, "R1 prio truncated");
        wr(a_prio(0), 32'h5);
        rd(a_prio(0), 32'h0, "R1 source 0 word");
        wr(a_prio(40), 32'h1);
        rd(a_prio(40), 32'h1, "R1 last source prio");

        // R2: enable map
        wr(a_en(1, 0), 32'hFFFF_FFFF);
        rd(a_en(1, 0), 32'hFFFF_FFFE, "R2 enable word0 bit0 reserved");
        wr(a_en(1, 1), 32'hFFFF_FFFF);
        rd(a_en(1, 1), 32'h0000_01FF, "R2 enable word1 upper bits absent");

        // R10: unmapped and misaligned
        rd(a_prio(41), 32'h0, "R10 prio beyond last source");
        rd(a_en(1, 2), 32'h0, "R10 enable word beyond last");
        wr(26'h10_0000, 32'h1234);
        rd(26'h10_0000, 32'h0, "R10 hole read");
        rd(26'h15, 32'h0, "R10 misaligned read");
        wr(26'h16, 32'h0);
        rd(a_prio(5), 32'h7, "R10 misaligned write ignored");
        rd(a_thr(2), 32'h0, "R10 missing context");
        rd(26'h20_0008, 32'h0, "R10 context block hole");

        // setup: ctx1 enables source 7 only; ctx0 enables 3,5,7,33
        wr(a_en(1, 0), 32'h0000_0080);
        wr(a_en(1, 1), 32'h0);
        wr(a_en(0, 0), 32'h0000_00A8);
        wr(a_en(0, 1), 32'h0000_0002);
        wr(a_prio(3), 32'd2);
        wr(a_prio(5), 32'd4);
        wr(a_prio(7), 32'd4);
        wr(a_prio(33), 32'd6);
        chk_irq(2'b00, "R4 nothing latched");

        // R13 + R4: one-cycle pulses stay latched
        pulse(bit_of(3) | bit_of(5) | bit_of(7));
        chk_irq(2'b11, "R13 latched after pulse");

        // R6 / R7: ordering, tie to lowest id, claim hides source
        rd(a_clm(0), 32'd5, "R6 tie to lowest id");
        rd(a_clm(0), 32'd7, "R6 next highest");
        chk_irq(2'b01, "R7 claimed source hidden from ctx1");
        rd(a_clm(1), 32'd0, "R7 ctx1 claim empty");
        rd(a_clm(0), 32'd3, "R6 lower priority last");
        chk_irq(2'b00, "R4 all claimed");
        rd(a_clm(0), 32'd0, "R6 nothing qualifies");

        // R3 / R4: strict threshold
        @(negedge clk);
        src_lvl[33] = 1'b1;
        @(negedge clk);
        chk_irq(2'b01, "R4 level source latched");
        wr(a_thr(0), 32'd6);
        rd(a_thr(0), 32'd6, "R3 threshold readback");
        chk_irq(2'b00, "R4 equal to threshold masked");
        rd(a_clm(0), 32'd0, "R6 claim respects threshold");
        wr(a_thr(0), 32'd5);
        chk_irq(2'b01, "R4 above threshold");
        rd(a_clm(0), 32'd33, "R6 claim above threshold");
        chk_irq(2'b00, "R7 claimed with level high");

        // R9: stray completions
        wr(a_clm(0), 32'd34);
        chk_irq(2'b00, "R9 unclaimed completion");
        wr(a_clm(0), 32'd0);
        wr(a_clm(0), 32'h0000_0421);
        chk_irq(2'b00, "R9 zero and out-of-range completion");
        rd(a_clm(0), 32'd0, "R9 nothing released");

        // R8: rearm with level high, release with level low via ctx1
        wr(a_clm(0), 32'd33);
        chk_irq(2'b01, "R8 rearm while level high");
        rd(a_clm(0), 32'd33, "R8 claim again");
        @(negedge clk);
        src_lvl[33] = 1'b0;
        wr(a_clm(1), 32'd33);
        chk_irq(2'b00, "R8 release through other context");
        rd(a_clm(0), 32'd0, "R8 idle after release");

        // R5: priority zero masking
        wr(a_clm(0), 32'd5);
        wr(a_clm(0), 32'd7);
        wr(a_clm(0), 32'd3);
        wr(a_thr(0), 32'd0);
        wr(a_prio(5), 32'd0);
        pulse(bit_of(5));
        chk_irq(2'b00, "R5 priority zero masked");
        rd(a_clm(0), 32'd0, "R5 masked source not claimed");
        wr(a_prio(5), 32'd3);
        chk_irq(2'b01, "R5 nonzero re-enables");
        rd(a_clm(0), 32'd5, "R5 claim after unmask");
        wr(a_clm(0), 32'd5);
        chk_irq(2'b00, "R8 release after unmask");

        repeat (3) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fails++;
            $display("FAIL R11: %0d responses missing expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule